// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sequences an external successive-approximation converter core through a scan of the channels marked in a select bitmap. A scan can be launched by a software start pulse or by a qualified edge on a hardware trigger line. It then runs in one of three ways: once through the whole scan, restarting on its own (continuous), or one channel per trigger (discontinuous). For each channel the controller asks the core to begin a conversion. It then waits for the core's end-of-sampling and completion pulses. The result is placed in a single data register, which is presented as a valid/ready output.

The data output follows a valid/ready rule. `dout_valid` rises when a result is stored and stays high until a cycle in which `dout_ready` is also high, which consumes the word. Without wait mode, a consumer that holds `dout_ready` low does not stall the scan: a result that completes over an unread word raises the overrun flag. In wait mode the back-pressure reaches the scan itself, because the next conversion is held until the word is consumed.

Four sticky status flags are kept, each with an interrupt enable, and a busy output reflects the start bit. An auto-power-off option drops the core's power enable whenever no conversion is under way.

Top module: `adcseq_ctrl`

## Requirements
- R1: The scan visits only the set bits of `cfg_chsel`. With `cfg_scan_down`=0 it goes from the lowest set channel upward; with `cfg_scan_down`=1 it goes from the highest set channel downward. `core_ch` carries the channel number in the cycle `core_start` is high.
- R2: With continuous mode off and discontinuous mode off, one trigger converts every selected channel in turn. At the last channel, the end-of-sequence flag is set and `busy` clears.
- R3: With `cfg_cont`=1 and `cfg_disc`=0, the scan restarts from the first channel after end-of-sequence without any new trigger, and `busy` stays high until a stop.
- R4: With `cfg_disc`=1, each trigger converts exactly one channel, and `busy` clears after the last channel. This holds even when `cfg_cont` is also 1, which then has no effect.
- R5: With `cfg_wait`=1, after each conversion the next one is not started until the data word has been consumed (`dout_valid` and `dout_ready` both high).
- R6: Hardware trigger edges that occur while a conversion is running, or during the wait-mode hold, are discarded and launch nothing later.
- R7: A `sw_stop` pulse clears `busy` at once. If a conversion is running, `core_abort` is raised and neither the data register nor the end-of-conversion flag is updated, even if the core completes in that same cycle.
- R8: With `cfg_autopoff`=1, `core_pwr_en` is low while idle, while waiting for a trigger and during the wait-mode hold. It is high from the cycle that follows the trigger or the consuming read through the end of the conversion. With `cfg_autopoff`=0 it is always high.
- R9: The trigger edge is selected by `cfg_trig_edge`: 0 = software only, where `sw_start` also acts as the trigger; 1 = rising; 2 = falling; 3 = both edges. With a nonzero setting, `sw_start` only arms the block.
- R10: A result that completes while the previous word is unread sets the overrun flag. With `cfg_ovrmod`=1 the register takes the new result; with `cfg_ovrmod`=0 it keeps the old one.
- R11: The flags are at bit 0 = end of sampling, bit 1 = end of conversion, bit 2 = end of sequence and bit 3 = overrun. They are sticky, and each is cleared by a 1 in the same bit of `flag_clr`; a set in the same cycle wins over the clear. `irq` is high when any flag is set together with its bit in `irq_en`.
- R12: After reset `busy`, `dout_valid`, `flags` and `core_start` are 0. `dout_valid` stays high until it is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chsel | input | NUM_CH | Channel select bitmap |
| cfg_scan_down | input | 1 | 1 = scan from highest channel downward |
| cfg_cont | input | 1 | Continuous restart of the scan |
| cfg_disc | input | 1 | One channel per trigger |
| cfg_wait | input | 1 | Hold next conversion until data is consumed |
| cfg_ovrmod | input | 1 | 1 = overwrite unread data on overrun |
| cfg_autopoff | input | 1 | Drop core power when not converting |
| cfg_trig_edge | input | 2 | Trigger edge: 0 none, 1 rise, 2 fall, 3 both |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| hw_trig | input | 1 | Hardware trigger line |
| core_pwr_en | output | 1 | Core power enable |
| core_start | output | 1 | Begin-conversion request to the core |
| core_abort | output | 1 | Abort of the running conversion |
| core_ch | output | CH_W | Channel for the requested conversion |
| core_smp_done | input | 1 | Core end-of-sampling pulse |
| core_done | input | 1 | Core completion pulse |
| core_result | input | RES_W | Core conversion result |
| dout_valid | output | 1 | Data word unread |
| dout_ready | input | 1 | Consumer takes the word |
| dout_data | output | RES_W | Data register |
| flags | output | 4 | Sticky status flags |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| irq_en | input | 4 | Interrupt enables per flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Start bit (scan active) |

## Verification
Two collisions matter most. The first is a stop request that lands in the very cycle the core reports completion. The bench provokes it by raising `sw_stop` at the falling edge where the model's completion pulse is already visible, so that both reach the same rising edge. It judges the outcome by the data register being unchanged, the end-of-conversion flag staying clear and `busy` dropping. The second is a new result that completes against an unread word. The bench forces it by holding `dout_ready` low across a two-channel scan, then checks the overrun flag and the register contents under both overwrite settings.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LAUNCH, ST_CONV, ST_HOLD
  } seq_state_t;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } trig_edge_t;

  localparam int FLG_EOSMP = 0;
  localparam int FLG_EOC   = 1;
  localparam int FLG_EOS   = 2;
  localparam int FLG_OVR   = 3;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/adcseq_trig_qual.sv
module adcseq_trig_qual
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] edge_sel,
  input  logic       hw_trig,
  output logic       trig_evt
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= hw_trig;
  end

  assign rise = hw_trig & ~prev_q;
  assign fall = ~hw_trig & prev_q;

  always_comb begin
    case (trig_edge_t'(edge_sel))
      EDGE_RISE: trig_evt = rise;
      EDGE_FALL: trig_evt = fall;
      EDGE_BOTH: trig_evt = rise | fall;
      default:   trig_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/adcseq_ch_pick.sv
module adcseq_ch_pick #(
  parameter int NUM_CH = 19,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] chsel,
  input  logic [CH_W-1:0]   cur,
  input  logic              down,
  output logic [CH_W-1:0]   first_ch,
  output logic [CH_W-1:0]   next_ch,
  output logic              is_last
);
  logic [CH_W-1:0] lo_ch, hi_ch, above_ch, below_ch;
  logic            has_above, has_below;

  // lowest set channel and the nearest set channel above cur
  always_comb begin
    lo_ch     = '0;
    above_ch  = '0;
    has_above = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chsel[i]) lo_ch = CH_W'(i);
      if (chsel[i] && (CH_W'(i) > cur)) begin
        above_ch  = CH_W'(i);
        has_above = 1'b1;
      end
    end
  end

  // highest set channel and the nearest set channel below cur
  always_comb begin
    hi_ch     = '0;
    below_ch  = '0;
    has_below = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chsel[i]) hi_ch = CH_W'(i);
      if (chsel[i] && (CH_W'(i) < cur)) begin
        below_ch  = CH_W'(i);
        has_below = 1'b1;
      end
    end
  end

  assign first_ch = down ? hi_ch : lo_ch;
  assign next_ch  = down ? below_ch : above_ch;
  assign is_last  = down ? ~has_below : ~has_above;
endmodule

// File: rtl/adcseq_flags.sv
module adcseq_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic [NF-1:0] en_vec,
  output logic [NF-1:0] flags,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign irq = |(flags & en_vec);
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 19,
  parameter int RES_W  = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cfg_chsel,
  input  logic              cfg_scan_down,
  input  logic              cfg_cont,
  input  logic              cfg_disc,
  input  logic              cfg_wait,
  input  logic              cfg_ovrmod,
  input  logic              cfg_autopoff,
  input  logic [1:0]        cfg_trig_edge,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              hw_trig,
  output logic              core_pwr_en,
  output logic              core_start,
  output logic              core_abort,
  output logic [CH_W-1:0]   core_ch,
  input  logic              core_smp_done,
  input  logic              core_done,
  input  logic [RES_W-1:0]  core_result,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [RES_W-1:0]  dout_data,
  output logic [3:0]        flags,
  input  logic [3:0]        flag_clr,
  input  logic [3:0]        irq_en,
  output logic              irq,
  output logic              busy
);
  seq_state_t       state_q, state_n;
  logic [CH_W-1:0]  cur_q, cur_n;
  logic             started_q, started_n;
  logic [RES_W-1:0] data_q;
  logic             valid_q;
  logic             trig_evt, sw_only, go_evt, cont_eff, rd, wr, ovr_hit;
  logic [CH_W-1:0]  first_ch, next_ch;
  logic             is_last;
  logic [NUM_FLAGS-1:0] flag_set;

  adcseq_trig_qual u_trig (
    .clk(clk), .rst_n(rst_n), .edge_sel(cfg_trig_edge),
    .hw_trig(hw_trig), .trig_evt(trig_evt)
  );

  adcseq_ch_pick #(.NUM_CH(NUM_CH)) u_pick (
    .chsel(cfg_chsel), .cur(cur_q), .down(cfg_scan_down),
    .first_ch(first_ch), .next_ch(next_ch), .is_last(is_last)
  );

  assign sw_only  = (trig_edge_t'(cfg_trig_edge) == EDGE_NONE);
  assign go_evt   = sw_only ? sw_start : trig_evt;
  assign cont_eff = cfg_cont & ~cfg_disc;
  assign rd       = valid_q & dout_ready;

  always_comb begin
    state_n    = state_q;
    cur_n      = cur_q;
    started_n  = started_q;
    core_abort = 1'b0;
    wr         = 1'b0;
    if (sw_stop) begin
      core_abort = (state_q == ST_CONV);
      state_n    = ST_IDLE;
      started_n  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (sw_start && |cfg_chsel) begin
          started_n = 1'b1;
          cur_n     = first_ch;
          state_n   = sw_only ? ST_LAUNCH : ST_ARM;
        end
        ST_ARM:    if (go_evt) state_n = ST_LAUNCH;
        ST_LAUNCH: state_n = ST_CONV;
        ST_CONV: if (core_done) begin
          wr = 1'b1;
          if (is_last && !cont_eff) begin
            state_n   = ST_IDLE;
            started_n = 1'b0;
          end else begin
            cur_n   = is_last ? first_ch : next_ch;
            state_n = cfg_wait ? ST_HOLD : (cfg_disc ? ST_ARM : ST_LAUNCH);
          end
        end
        ST_HOLD: if (rd) state_n = cfg_disc ? ST_ARM : ST_LAUNCH;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  assign ovr_hit = wr & valid_q & ~rd;

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_EOSMP] = !sw_stop && (state_q == ST_CONV) && core_smp_done;
    flag_set[FLG_EOC]   = wr;
    flag_set[FLG_EOS]   = wr & is_last;
    flag_set[FLG_OVR]   = ovr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      started_q <= 1'b0;
      data_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      state_q   <= state_n;
      cur_q     <= cur_n;
      started_q <= started_n;
      if (wr) begin
        if (!ovr_hit || cfg_ovrmod) data_q <= core_result;
        valid_q <= 1'b1;
      end else if (rd) begin
        valid_q <= 1'b0;
      end
    end
  end

  adcseq_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(flag_set), .clr_vec(flag_clr),
    .en_vec(irq_en), .flags(flags), .irq(irq)
  );

  assign core_start  = (state_q == ST_LAUNCH);
  assign core_ch     = cur_q;
  assign core_pwr_en = !cfg_autopoff || (state_q == ST_LAUNCH) || (state_q == ST_CONV);
  assign dout_valid  = valid_q;
  assign dout_data   = data_q;
  assign busy        = started_q;
endmodule

// File: rtl/adcseq_ctrl_chk.sv
module adcseq_ctrl_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_stop,
  input logic             busy,
  input logic             core_start,
  input logic             core_pwr_en,
  input logic             dout_valid,
  input logic             dout_ready,
  input logic [RES_W-1:0] dout_data,
  input logic             cfg_ovrmod,
  input logic [3:0]       flags,
  input logic [3:0]       flag_clr
);
  AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> ($stable(dout_data) && !busy)); // R7
  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> core_pwr_en); // R8
  AST_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> busy); // R2
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> dout_valid); // R12
  AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ovrmod && dout_valid && !dout_ready) |=> $stable(dout_data)); // R10

  for (genvar g = 0; g < 4; g++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !flag_clr[g]) |=> flags[g]); // R11
  end
endmodule

bind adcseq_ctrl adcseq_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_stop(sw_stop), .busy(busy),
  .core_start(core_start), .core_pwr_en(core_pwr_en),
  .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
  .cfg_ovrmod(cfg_ovrmod), .flags(flags), .flag_clr(flag_clr)
);

// File: tb/tb_adcseq_ctrl.sv
`timescale 1ns/1ps
module tb_adcseq_ctrl;
  localparam int NUM_CH = 19;
  localparam int RES_W  = 12;
  localparam int CH_W   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NUM_CH-1:0] cfg_chsel = '0;
  logic cfg_scan_down = 0, cfg_cont = 0, cfg_disc = 0, cfg_wait = 0;
  logic cfg_ovrmod = 0, cfg_autopoff = 0;
  logic [1:0] cfg_trig_edge = 2'd0;
  logic sw_start = 0, sw_stop = 0, hw_trig = 0;
  logic core_pwr_en, core_start, core_abort;
  logic [CH_W-1:0] core_ch;
  logic core_smp_done, core_done;
  logic [RES_W-1:0] core_result;
  logic dout_valid, dout_ready = 1'b1;
  logic [RES_W-1:0] dout_data;
  logic [3:0] flags, flag_clr = 4'h0, irq_en = 4'h0;
  logic irq, busy;

  adcseq_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) dut (.*);

  // converter core model
  int conv_cycles = 6;
  int m_cnt, m_serial;
  logic [CH_W-1:0] m_ch;

  function automatic logic [RES_W-1:0] mval(int ch, int s);
    return RES_W'(ch * 128 + (s % 128));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_serial <= 0; m_ch <= '0;
      core_smp_done <= 0; core_done <= 0; core_result <= '0;
    end else begin
      core_smp_done <= 0;
      core_done     <= 0;
      if (core_abort) m_cnt <= 0;
      else if (core_start) begin
        m_cnt <= conv_cycles; m_ch <= core_ch;
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        core_smp_done <= (m_cnt == conv_cycles);
        if (m_cnt == 1) begin
          core_done   <= 1'b1;
          core_result <= mval(int'(m_ch), m_serial);
          m_serial    <= m_serial + 1;
        end
      end
    end
  end

  // start monitor
  int log_ch[64];
  int nlog = 0;
  always @(posedge clk) if (rst_n && core_start && nlog < 64) begin
    log_ch[nlog] = int'(core_ch);
    nlog = nlog + 1;
  end

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pstart();
    sw_start = 1; @(negedge clk); sw_start = 0;
  endtask

  task automatic pstop();
    sw_stop = 1; @(negedge clk); sw_stop = 0;
  endtask

  task automatic pread();
    dout_ready = 1; @(negedge clk); dout_ready = 0;
  endtask

  task automatic clrflags();
    flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    cyc(2);
  endtask

  task automatic ptrig();
    hw_trig = 1; @(negedge clk); hw_trig = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  logic [NUM_CH-1:0] pats[8];
  int exp_ord[NUM_CH];

  initial begin
    int ne, s0;
    logic [RES_W-1:0] d0;
    bit ok;
    pats[0] = 19'h00001; pats[1] = 19'h40000; pats[2] = 19'h7FFFF;
    pats[3] = 19'h15555; pats[4] = 19'h2AAAA; pats[5] = 19'h00300;
    pats[6] = 19'h40001; pats[7] = 19'h12345;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R12 reset state
    check(!busy && !dout_valid && flags == 0 && !core_start, "R12 reset",
          int'({busy, dout_valid, flags}), 0);

    // R1/R2 sweep over bitmaps and directions
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 2; d++) begin
        cfg_chsel = pats[p]; cfg_scan_down = d[0];
        ne = 0;
        if (d == 0) begin
          for (int i = 0; i < NUM_CH; i++) if (pats[p][i]) begin exp_ord[ne] = i; ne++; end
        end else begin
          for (int i = NUM_CH - 1; i >= 0; i--) if (pats[p][i]) begin exp_ord[ne] = i; ne++; end
        end
        clrflags();
        nlog = 0;
        pstart();
        wait_idle();
        ok = (nlog == ne);
        for (int i = 0; i < ne && ok; i++) if (log_ch[i] != exp_ord[i]) ok = 0;
        check(ok, "R1 scan order", nlog, ne);
        check(flags[2] && !busy && dout_data == mval(exp_ord[ne-1], m_serial - 1),
              "R2 single sequence end", int'(dout_data), int'(mval(exp_ord[ne-1], m_serial - 1)));
      end
    end

    // R3 continuous
    cfg_chsel = 19'h00105; cfg_scan_down = 0; cfg_cont = 1;
    nlog = 0;
    pstart();
    for (int k = 0; k < 500 && nlog < 7; k++) @(negedge clk);
    check(busy && log_ch[3] == 0 && log_ch[4] == 2 && log_ch[5] == 8 && log_ch[6] == 0,
          "R3 continuous restart", log_ch[3], 0);
    pstop();
    cyc(1);
    check(!busy, "R7 stop clears busy", busy, 0);
    cyc(20);

    // R4 discontinuous with continuous set
    cfg_disc = 1; cfg_chsel = 19'h00212; nlog = 0;
    pstart(); cyc(40);
    check(nlog == 1 && busy, "R4 one channel per trigger", nlog, 1);
    pstart(); cyc(40);
    check(nlog == 2 && busy, "R4 second trigger", nlog, 2);
    pstart(); cyc(40);
    check(nlog == 3 && !busy, "R4 continuous ignored", busy, 0);
    cfg_cont = 0; cfg_disc = 0;

    // R5 wait mode
    cfg_wait = 1; dout_ready = 0; cfg_chsel = 19'h000A8; nlog = 0;
    pread();
    pstart(); cyc(60);
    check(nlog == 1 && dout_valid, "R5 held until read", nlog, 1);
    pread(); cyc(60);
    check(nlog == 2, "R5 resumes after read", nlog, 2);
    dout_ready = 1; wait_idle();
    check(nlog == 3, "R5 sequence completes", nlog, 3);

    // R6 triggers during conversion and hold are dropped
    cfg_trig_edge = 2'd1; cfg_disc = 1; dout_ready = 0; cfg_chsel = 19'h00444; nlog = 0;
    pstart(); cyc(5);
    check(nlog == 0 && busy, "R9 armed waits for edge", nlog, 0);
    ptrig(); cyc(3);
    ptrig(); cyc(40);
    check(nlog == 1, "R6 trigger in conversion dropped", nlog, 1);
    ptrig(); cyc(5);
    pread(); cyc(40);
    check(nlog == 1, "R6 trigger in hold dropped", nlog, 1);
    ptrig(); cyc(40);
    check(nlog == 2, "R6 fresh trigger accepted", nlog, 2);
    pstop(); cyc(2);
    cfg_wait = 0; cfg_disc = 0; dout_ready = 1;

    // R9 falling and both edge selections
    cfg_trig_edge = 2'd2; cfg_chsel = 19'h00030; nlog = 0;
    pstart();
    hw_trig = 1; cyc(20);
    check(nlog == 0, "R9 rising ignored in falling mode", nlog, 0);
    hw_trig = 0; cyc(40);
    check(nlog == 2 && !busy, "R9 falling edge triggers", nlog, 2);
    cfg_trig_edge = 2'd3; nlog = 0;
    pstart();
    hw_trig = 1; cyc(40);
    check(nlog == 2 && !busy, "R9 both-edge triggers on rise", nlog, 2);
    hw_trig = 0; cyc(2);
    cfg_trig_edge = 2'd0;

    // R7 stop mid conversion and stop colliding with completion
    cfg_chsel = 19'h00060; clrflags(); d0 = dout_data; nlog = 0;
    pstart();
    for (int k = 0; k < 100 && nlog == 0; k++) @(negedge clk);
    cyc(2); pstop(); cyc(20);
    check(!busy && dout_data == d0 && !flags[1] && nlog == 1, "R7 abort no write",
          int'(dout_data), int'(d0));
    pstart();
    for (int k = 0; k < 100 && !core_done; k++) @(negedge clk);
    sw_stop = 1; @(negedge clk); sw_stop = 0;
    cyc(2);
    check(!busy && dout_data == d0 && !flags[1], "R7 stop wins over completion",
          int'(flags[1]), 0);

    // R10 overrun both modes, R12 valid holds
    cfg_chsel = 19'h00006; clrflags(); dout_ready = 0;
    s0 = m_serial;
    pstart(); wait_idle();
    check(flags[3] && dout_data == mval(1, s0), "R10 overrun keeps old",
          int'(dout_data), int'(mval(1, s0)));
    check(dout_valid, "R12 valid held while unread", dout_valid, 1);
    pread();
    check(!dout_valid, "R12 read consumes", dout_valid, 0);
    cfg_ovrmod = 1; clrflags(); s0 = m_serial;
    pstart(); wait_idle();
    check(flags[3] && dout_data == mval(2, s0 + 1), "R10 overrun overwrites",
          int'(dout_data), int'(mval(2, s0 + 1)));
    pread(); cfg_ovrmod = 0;

    // R8 auto power off
    cfg_autopoff = 1; cfg_trig_edge = 2'd1; cfg_wait = 1; cfg_chsel = 19'h00030;
    cyc(1);
    check(!core_pwr_en, "R8 off when idle", core_pwr_en, 0);
    pstart(); cyc(2);
    check(!core_pwr_en, "R8 off while armed", core_pwr_en, 0);
    ptrig(); cyc(2);
    check(core_pwr_en, "R8 on during conversion", core_pwr_en, 1);
    cyc(30);
    check(!core_pwr_en && dout_valid, "R8 off during hold", core_pwr_en, 0);
    dout_ready = 1; @(negedge clk); dout_ready = 0;
    check(core_pwr_en, "R8 on after read", core_pwr_en, 1);
    dout_ready = 1; wait_idle();
    cfg_autopoff = 0; cfg_wait = 0; cfg_trig_edge = 2'd0; cyc(1);
    check(core_pwr_en, "R8 on when feature off", core_pwr_en, 1);

    // R11 flags and interrupt
    clrflags();
    cfg_chsel = 19'h00001; pstart(); wait_idle();
    check(flags == 4'b0111, "R11 flags after one conversion", int'(flags), 7);
    irq_en = 4'b0010; cyc(1);
    check(irq, "R11 irq from enabled flag", irq, 1);
    flag_clr = 4'b0010; @(negedge clk); flag_clr = 4'b0000;
    check(flags == 4'b0101 && !irq, "R11 write-one clear", int'(flags), 5);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule